// File: doc/BRIEF.md
# Run-Time Selectable Serial Delay Line

This block is a single-bit serial delay line with sixteen storage stages and an output tap that is picked while it runs. On every rising clock edge with the clock enable high, the serial input is captured into the first stage and every other stage takes the value of the stage before it. With the enable low, nothing moves. A tap address chooses which stage drives the data output, so the delay from input to output can be set anywhere from one to sixteen enabled edges. The address may change on any cycle, and it reaches the output through combinational logic only.

The last stage is always brought out on its own cascade pin. Feeding that pin into the serial input of a second instance builds a longer line, so two instances give up to thirty-two cycles of delay. A mode parameter adds one flip-flop after the tap for an extra cycle of delay and a clean registered output. The storage stages have no set or reset, which leaves them free to map onto a lookup table used as a shift register. The reset input only clears that optional output flip-flop.

Top module: `dyn_delay_line`

## Requirements
- R1: On a rising edge with `ce` high, `din` is stored in stage 0 and each stage i (1 to 15) takes the old value of stage i-1; with address 0 the output then shows that just-stored `din` bit.
- R2: On a rising edge with `ce` low, no stage changes, so `dout`, `cascade_out` and the registered output keep their values whatever `din` does.
- R3: With tap address k (0 to 15), `dout` in the combinational mode equals the `din` bit that was stored k+1 enabled edges earlier.
- R4: A change of the tap address shows on `dout` within the same cycle, with no clock edge in between.
- R5: `cascade_out` always equals stage 15, the `din` bit stored 16 enabled edges earlier, whatever the tap address.
- R6: When `cascade_out` of one instance drives `din` of a second with the same `ce`, the second instance's tap k gives the first instance's input delayed by 16+k+1 enabled edges.
- R7: With `OUT_MODE` set to the registered mode, `dout` is updated from the selected stage only on rising edges with `ce` high, adding exactly one enabled edge of delay.
- R8: `rst` is synchronous and active high; it sets the registered output to 0 and has no effect on the stored stages, so `cascade_out` and the combinational `dout` are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear of the registered output only |
| ce | input | 1 | Clock enable for shifting and for the registered output |
| din | input | 1 | Serial data input into stage 0 |
| tap_addr | input | ADDR_W (4) | Selects the stage that drives `dout` |
| dout | output | 1 | Selected stage, direct or through one flip-flop per `OUT_MODE` |
| cascade_out | output | 1 | Last stage, for chaining into a further instance |

## Verification
The line is first flushed with known bits, since its stages power up undefined, and is then driven with a random bit stream, random enable gaps and a tap address that jumps each cycle; this separates a correct stage selection from an off-by-one delay and catches any shifting while the enable is low. An isolated single one in a field of zeros then shows which stage it occupies, telling an address decode error apart from a shifting error. A sweep of all sixteen addresses with the clock stopped shows the tap path is combinational. Two chained instances, the second registered, confirm the cascade pin and the extra registered cycle, and a reset in mid-stream shows that only the output flip-flop is cleared.

// File: rtl/dly_pkg.sv
package dly_pkg;
  // Output path variants of the delay line.
  typedef enum logic {
    TAP_COMB = 1'b0,
    TAP_REG  = 1'b1
  } tap_mode_e;
endpackage

// File: rtl/dly_stage_chain.sv
module dly_stage_chain #(
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             din,
  output logic [DEPTH-1:0] stages
);
  // Storage deliberately carries no reset so that it can sit in a LUT shifter.
  logic [DEPTH-1:0] sr;

  always_ff @(posedge clk) begin
    if (ce) sr <= {sr[DEPTH-2:0], din};
  end

  assign stages = sr;

  // R1: input lands in stage 0 on an enabled edge
  p_shift_in_r1: assert property (@(posedge clk) disable iff (rst)
    ce |=> sr[0] == $past(din));

  // R1: every stage advances by one on an enabled edge
  p_advance_r1: assert property (@(posedge clk) disable iff (rst)
    ce |=> sr[DEPTH-1:1] == $past(sr[DEPTH-2:0]));

  // R2: all stages hold while the enable is low
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(sr));
endmodule

// File: rtl/dly_tap_mux.sv
module dly_tap_mux #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]  stages,
  input  logic [ADDR_W-1:0] sel,
  output logic              tap
);
  // Pure combinational selection: address k picks stage k (delay k+1).
  always_comb begin
    tap = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel == ADDR_W'(i)) tap = stages[i];
    end
  end
endmodule

// File: rtl/dly_out_reg.sv
module dly_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (ce) q <= d;
  end

  // R8: synchronous reset clears the output flop
  p_rst_clear_r8: assert property (@(posedge clk)
    rst |=> q == 1'b0);

  // R7: registered output follows the tap on an enabled edge
  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    ce |=> q == $past(d));

  // R7: registered output holds while the enable is low
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(q));
endmodule

// File: rtl/dyn_delay_line.sv
module dyn_delay_line
  import dly_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter tap_mode_e   OUT_MODE = TAP_COMB,
  localparam int unsigned ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              din,
  input  logic [ADDR_W-1:0] tap_addr,
  output logic              dout,
  output logic              cascade_out
);
  logic [DEPTH-1:0] stages;
  logic             tap;

  dly_stage_chain #(.DEPTH(DEPTH)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .din    (din),
    .stages (stages)
  );

  dly_tap_mux #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mux (
    .stages (stages),
    .sel    (tap_addr),
    .tap    (tap)
  );

  generate
    if (OUT_MODE == TAP_REG) begin : g_reg_out
      dly_out_reg u_oreg (
        .clk (clk),
        .rst (rst),
        .ce  (ce),
        .d   (tap),
        .q   (dout)
      );
    end else begin : g_comb_out
      assign dout = tap;
    end
  endgenerate

  assign cascade_out = stages[DEPTH-1];

  // R5: the cascade pin advances from the stage before it on enabled edges
  p_cascade_r5: assert property (@(posedge clk) disable iff (rst)
    ce |=> cascade_out == $past(stages[DEPTH-2]));

  // R5: the cascade pin never moves without an enabled edge
  p_cascade_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(cascade_out));
endmodule

// File: tb/dyn_delay_line_tb_top.sv
`timescale 1ns/1ps
module dyn_delay_line_tb_top;
  import dly_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce = 1'b0;
  logic       din = 1'b0;
  logic [3:0] addr_a = 4'd0;
  logic [3:0] addr_b = 4'd0;
  logic       dout_a, casc_a, dout_b, casc_b;

  int checks = 0;
  int errors = 0;
  logic [63:0] hist = '0;   // hist[0] = most recently shifted bit
  logic        exp_q = 1'b0;

  always #5 clk = ~clk;

  dyn_delay_line #(.DEPTH(16), .OUT_MODE(TAP_COMB)) dut_i (
    .clk(clk), .rst(rst), .ce(ce), .din(din), .tap_addr(addr_a),
    .dout(dout_a), .cascade_out(casc_a));

  dyn_delay_line #(.DEPTH(16), .OUT_MODE(TAP_REG)) dut_reg_i (
    .clk(clk), .rst(rst), .ce(ce), .din(casc_a), .tap_addr(addr_b),
    .dout(dout_b), .cascade_out(casc_b));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_tap(input logic [3:0] k);
    return hist[k];
  endfunction

  function automatic logic exp_chain_tap(input logic [3:0] k);
    return hist[16 + k];
  endfunction

  task automatic step(input logic c, input logic d, input logic [3:0] ka,
                      input logic [3:0] kb, input logic r, input bit chk);
    ce = c; din = d; addr_a = ka; addr_b = kb; rst = r;
    @(posedge clk);
    if (r)      exp_q = 1'b0;
    else if (c) exp_q = exp_chain_tap(kb);
    if (c) hist = {hist[62:0], d};
    #2;
    if (chk) begin
      check((ka == 4'd0) ? "R1" : "R3", dout_a, exp_tap(ka));
      check("R5", casc_a, hist[15]);
      check(r ? "R8" : "R6 R7", dout_b, exp_q);
    end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    // Reset state of the registered output
    repeat (3) step(1'b0, 1'b0, 4'd0, 4'd0, 1'b1, 1'b0);
    check("R8", dout_b, 1'b0);
    // Flush both instances with known bits
    for (int i = 0; i < 40; i++) step(1'b1, i[0] ^ i[2], 4'd0, 4'd0, 1'b0, 1'b0);
    // Walking single one through zeros
    step(1'b1, 1'b1, 4'd0, 4'd0, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 4'(i), 4'(i + 3), 1'b0, 1'b1);
    // Enable low: din toggles, nothing may move
    begin
      logic ca, da, db;
      ca = casc_a; da = dout_a; db = dout_b;
      for (int i = 0; i < 6; i++) step(1'b0, i[0], 4'd7, 4'd2, 1'b0, 1'b1);
      check("R2", casc_a, ca);
      check("R2", dout_a, da);
      check("R2", dout_b, db);
    end
    // Address sweep with the clock effectively idle (enable low)
    ce = 1'b0;
    for (int k = 0; k < 16; k++) begin
      addr_a = 4'(k);
      #1;
      check("R4", dout_a, exp_tap(4'(k)));
    end
    // Mid-stream reset with enable low: stages untouched, flop cleared
    begin
      logic ca;
      ca = casc_a;
      step(1'b0, 1'b1, 4'd5, 4'd5, 1'b1, 1'b1);
      check("R8", casc_a, ca);
      check("R8", dout_a, exp_tap(4'd5));
      check("R8", dout_b, 1'b0);
    end
    // Random stream with enable gaps and jumping taps
    for (int i = 0; i < 500; i++) begin
      step(($urandom % 4) != 0, 1'($urandom), 4'($urandom), 4'($urandom),
           1'b0, 1'b1);
    end
    // Extreme taps after random traffic
    step(1'b1, 1'b1, 4'd15, 4'd15, 1'b0, 1'b1);
    step(1'b1, 1'b0, 4'd0, 4'd0, 1'b0, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule